// File: doc/BRIEF.md
# Dual-Mode Burst Address Sequencer

This block produces the address a synchronous memory array sees during a four-beat burst. When the access controller asserts the load qualifier, the block registers the external address. The upper bits are held as the burst base. The two low bits become the starting point of the burst.

Each later cycle where the active-low advance input is asserted and no load is present moves the burst forward by one beat. The low bits of the presented address follow one of two orders, picked by a mode input that is registered inside the block:
- Interleaved order: the start XOR the beat count.
- Linear order: the start plus the beat count, wrapping within the group of four.

The beat position is kept in a small state machine with these states:
- `ST_IDLE`: no burst has been loaded since reset.
- `ST_BEAT0` to `ST_BEAT3`: the current beat.

Its transitions are:
- load: any state goes to `ST_BEAT0`.
- step: `ST_BEATn` goes to `ST_BEATn+1`, and `ST_BEAT3` wraps to `ST_BEAT0`.
- hold: the state stays where it is when advance is high.
- idle-stay: `ST_IDLE` ignores advance.

Top module: `burst_seq`

## Requirements
- R1: While reset is asserted and directly after it, `addr_o` is 0 and `beat_o` is 0.
- R2: In the cycle after a clock edge that sees `load_i` high, `addr_o` equals the `addr_i` sampled at that edge, and `beat_o` is 0.
- R3: When `load_i` is high and `adv_n_i` is low at the same edge, the load wins: `beat_o` is 0 and `addr_o` is the new address.
- R4: During a burst, an edge with `load_i` low and `adv_n_i` low increments `beat_o` by one.
- R5: An edge with `load_i` low and `adv_n_i` high leaves `beat_o` unchanged. If the mode is also unchanged, `addr_o` is unchanged as well.
- R6: With the registered mode at 1 (interleaved), `addr_o[1:0]` equals start XOR `beat_o`. For example, start 01 gives 01, 00, 11, 10.
- R7: With the registered mode at 0 (linear), `addr_o[1:0]` equals (start + `beat_o`) mod 4. For example, start 01 gives 01, 10, 11, 00.
- R8: An advance from beat 3 returns to beat 0, and the low bits return to the start value with no carry into the upper bits.
- R9: `mode_i` is sampled at each rising edge, and the sampled value governs `addr_o` until the next edge. A change between edges has no effect on `addr_o` before the next edge.
- R10: `addr_o[ADDR_W-1:2]` equals the upper bits of the last loaded address and changes only on a load.
- R11: Before the first load after reset, advances have no effect: `beat_o` and `addr_o` stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_i | input | 1 | Load qualifier from the access controller |
| adv_n_i | input | 1 | Active-low advance |
| mode_i | input | 1 | Order select: 1 interleaved, 0 linear |
| addr_i | input | ADDR_W | External address |
| addr_o | output | ADDR_W | Current burst address |
| beat_o | output | 2 | Current beat count, 0 to 3 |

## Verification
Two pairs of functions can fall in the same cycle.

The first pair is a load and an advance. The bench provokes this by asserting `load_i` and `adv_n_i` together partway through a running burst. It judges the result by requiring beat 0 and the new address one cycle later, with no step applied.

The second pair is a mode change and a held burst. The bench flips `mode_i` between edges while advance is high. It expects the address to stay put until the next edge and then to switch to the other order at the same beat.

// File: rtl/bseq_pkg.sv
package bseq_pkg;
    localparam int LOW_W = 2;
    localparam int BEATS = 1 << LOW_W;

    typedef logic [LOW_W-1:0] low_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_BEAT0,
        ST_BEAT1,
        ST_BEAT2,
        ST_BEAT3
    } beat_state_e;
endpackage

// File: rtl/bseq_beat_fsm.sv
module bseq_beat_fsm
    import bseq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic adv_n_i,
    output low_t beat_o,
    output logic active_o
);
    beat_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  state_d = load_i ? ST_BEAT0 : ST_IDLE;
            ST_BEAT0: state_d = load_i ? ST_BEAT0 : (!adv_n_i ? ST_BEAT1 : ST_BEAT0);
            ST_BEAT1: state_d = load_i ? ST_BEAT0 : (!adv_n_i ? ST_BEAT2 : ST_BEAT1);
            ST_BEAT2: state_d = load_i ? ST_BEAT0 : (!adv_n_i ? ST_BEAT3 : ST_BEAT2);
            ST_BEAT3: state_d = load_i ? ST_BEAT0 : (!adv_n_i ? ST_BEAT0 : ST_BEAT3);
            default:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        beat_o   = '0;
        active_o = 1'b1;
        unique case (state_q)
            ST_IDLE:  begin beat_o = low_t'(0); active_o = 1'b0; end
            ST_BEAT0: beat_o = low_t'(0);
            ST_BEAT1: beat_o = low_t'(1);
            ST_BEAT2: beat_o = low_t'(2);
            ST_BEAT3: beat_o = low_t'(3);
            default:  begin beat_o = low_t'(0); active_o = 1'b0; end
        endcase
    end

    AST_LOAD_TO_BEAT0: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (beat_o == '0) && active_o); // R2
    AST_LOAD_BEATS_ADV: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && !adv_n_i) |=> (beat_o == '0)); // R3
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (active_o && !load_i && !adv_n_i) |=> (beat_o == low_t'($past(beat_o) + 1'b1))); // R4
    AST_HOLD_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && adv_n_i) |=> $stable(beat_o)); // R5
    AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (!active_o && !load_i) |=> !active_o && (beat_o == '0)); // R11
endmodule

// File: rtl/bseq_addr_reg.sv
module bseq_addr_reg
    import bseq_pkg::*;
#(
    parameter int ADDR_W = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [ADDR_W-LOW_W-1:0] base_o,
    output low_t              start_o
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_o  <= '0;
            start_o <= '0;
        end else if (load_i) begin
            base_o  <= addr_i[ADDR_W-1:LOW_W];
            start_o <= addr_i[LOW_W-1:0];
        end
    end
endmodule

// File: rtl/bseq_mode_reg.sv
module bseq_mode_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic mode_i,
    output logic mode_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= 1'b0;
        else        mode_q <= mode_i;
    end
endmodule

// File: rtl/bseq_order.sv
module bseq_order
    import bseq_pkg::*;
(
    input  logic mode_i,
    input  low_t start_i,
    input  low_t beat_i,
    output low_t low_o
);
    low_t ilv, lin;

    always_comb begin
        ilv   = start_i ^ beat_i;
        lin   = low_t'(start_i + beat_i);
        low_o = mode_i ? ilv : lin;
    end
endmodule

// File: rtl/burst_seq.sv
module burst_seq
    import bseq_pkg::*;
#(
    parameter int ADDR_W = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              adv_n_i,
    input  logic              mode_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [LOW_W-1:0]  beat_o
);
    localparam int HI_W = ADDR_W - LOW_W;

    logic [HI_W-1:0] base;
    low_t start, beat, low;
    logic mode_q, active;

    bseq_beat_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .adv_n_i(adv_n_i),
        .beat_o(beat), .active_o(active)
    );

    bseq_addr_reg #(.ADDR_W(ADDR_W)) u_areg (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .addr_i(addr_i),
        .base_o(base), .start_o(start)
    );

    bseq_mode_reg u_mreg (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .mode_q(mode_q)
    );

    bseq_order u_order (
        .mode_i(mode_q), .start_i(start), .beat_i(beat), .low_o(low)
    );

    assign addr_o = {base, low};
    assign beat_o = beat;

    AST_FIRST_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (addr_o == $past(addr_i))); // R2
    AST_UPPER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(addr_o[ADDR_W-1:LOW_W])); // R10
    AST_HOLD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && adv_n_i && (mode_i == mode_q)) |=> $stable(addr_o)); // R5
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !load_i) |=> (addr_o == '0)); // R11
endmodule

// File: tb/burst_seq_bench.sv
module burst_seq_bench;
    localparam int AW = 17;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          load_i = 1'b0;
    logic          adv_n_i = 1'b1;
    logic          mode_i = 1'b0;
    logic [AW-1:0] addr_i = '0;
    logic [AW-1:0] addr_o;
    logic [1:0]    beat_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    burst_seq #(.ADDR_W(AW)) u_burst_seq (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .adv_n_i(adv_n_i),
        .mode_i(mode_i), .addr_i(addr_i), .addr_o(addr_o), .beat_o(beat_o)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [1:0] exp_low(input bit m, input logic [1:0] s, input logic [1:0] b);
        return m ? (s ^ b) : 2'((s + b) % 4);
    endfunction

    task automatic load_addr(input logic [AW-1:0] a, input bit adv);
        load_i  = 1'b1;
        adv_n_i = adv ? 1'b0 : 1'b1;
        addr_i  = a;
        tick();
        load_i  = 1'b0;
        adv_n_i = 1'b1;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [AW-1:0] a;
        #1;
        tick();
        tick();
        check("R1 addr in reset", addr_o, '0);
        check("R1 beat in reset", AW'(beat_o), '0);
        rst_n = 1'b1;
        tick();
        check("R1 addr after reset", addr_o, '0);

        // R11: advance before any load
        adv_n_i = 1'b0;
        for (int i = 0; i < 3; i++) begin
            tick();
            check("R11 idle addr", addr_o, '0);
            check("R11 idle beat", AW'(beat_o), '0);
        end
        adv_n_i = 1'b1;

        // Exhaustive sweep of mode x start, covering R2 R4 R5 R6 R7 R8 R10
        for (int m = 0; m < 2; m++) begin
            for (int s = 0; s < 4; s++) begin
                a = AW'((((m * 4 + s) * 37 + 5) << 2) | s);
                mode_i = m[0];
                load_addr(a, 1'b0);
                check("R2 loaded addr", addr_o, a);
                check("R2 beat zero", AW'(beat_o), '0);
                for (int b = 1; b <= 6; b++) begin
                    adv_n_i = 1'b0;
                    tick();
                    check(b >= 4 ? "R8 wrap beat" : "R4 beat step", AW'(beat_o), AW'(b % 4));
                    check(m ? "R6 interleaved low" : "R7 linear low",
                          AW'(addr_o[1:0]), AW'(exp_low(m[0], 2'(s), 2'(b % 4))));
                    check("R10 upper bits", addr_o >> 2, a >> 2);
                end
                adv_n_i = 1'b1;
                tick();
                tick();
                check("R5 hold beat", AW'(beat_o), AW'(2));
                check("R5 hold addr", addr_o, {a[AW-1:2], exp_low(m[0], 2'(s), 2'd2)});
            end
        end

        // R3: load and advance in the same cycle
        mode_i = 1'b0;
        load_addr(AW'(17'h1_2345), 1'b0);
        adv_n_i = 1'b0;
        tick();
        tick();
        load_addr(AW'(17'h0_ABCE), 1'b1);
        check("R3 collision addr", addr_o, AW'(17'h0_ABCE));
        check("R3 collision beat", AW'(beat_o), '0);

        // R9: mode flip between edges during a hold
        mode_i = 1'b0;
        load_addr(AW'(17'h0_0041), 1'b0);
        adv_n_i = 1'b0;
        tick();
        adv_n_i = 1'b1;
        check("R9 linear beat1", AW'(addr_o[1:0]), AW'(2'b10));
        mode_i = 1'b1;
        #2;
        check("R9 before edge", AW'(addr_o[1:0]), AW'(2'b10));
        tick();
        check("R9 after edge", AW'(addr_o[1:0]), AW'(2'b00));
        check("R9 beat kept", AW'(beat_o), AW'(1));
        mode_i = 1'b0;
        tick();
        check("R9 back to linear", AW'(addr_o[1:0]), AW'(2'b10));

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule